// File: doc/BRIEF.md
# Filter Run and Stop Sequencer

This block sits between the configuration registers of a multi-channel sigma-delta filter subsystem and its datapaths. It takes one global enable, a per-channel enable bit for each input channel and a per-filter enable bit for each decimation filter. From these it produces registered control signals. Each channel gets a qualifier that says whether it may take in data, split by where the data comes from: the serial receiver, fed by an external modulator, or the parallel word path, written by the CPU or DMA. Each filter gets a run level, a one-cycle initialize strobe and a one-cycle status-clear strobe.

A filter's effective enable is the global enable AND its own bit. When the effective enable rises, the filter's sinc stage and integrator stage are reinitialized. When it falls, any conversion in progress is stopped at once. The filter's watchdog and interrupt flags are then wiped, and its configuration is left alone. Dropping the global enable stops every channel and filter together. A registered clock-stop request tells the clock controller when no filter has an effective enable, so the processing clock may be gated.

Top module: `sdf_run_ctrl`

## Requirements
- R1: `ch_act[i]` equals `glb_en & ch_en[i]` as sampled at the previous rising clock edge.
- R2: `ch_src_sel[i]` value 0 selects the serial source and value 1 selects the parallel source. `ch_ser_act[i]` is `ch_act[i]` with serial selected, and `ch_par_act[i]` is `ch_act[i]` with parallel selected. Both are 0 while the channel is inactive, and they are never 1 together.
- R3: `flt_run[j]` equals the effective enable `glb_en & flt_en[j]` as sampled at the previous rising clock edge.
- R4: `flt_init[j]` is high for exactly one cycle: the first cycle in which `flt_run[j]` is high after being low. It stays low while `flt_run[j]` holds steady.
- R5: `flt_stclr[j]` is high for exactly one cycle: the cycle in which `flt_run[j]` first reads low after being high. It is never high together with `flt_init[j]`.
- R6: If `glb_en` is 0 at an edge, every `ch_act`, `ch_ser_act`, `ch_par_act` and `flt_run` bit is 0 after that edge, whatever the individual enables are. Each filter that was running gets its `flt_stclr` pulse in that same cycle.
- R7: `clk_stop_req` is 1 exactly when every `flt_run` bit is 0. It goes to 0 in the same cycle that any `flt_run` bit rises.
- R8: While `rst` is high at an edge, all outputs go to 0 except `clk_stop_req`, which goes to 1. The first effective enable seen after reset produces an `flt_init` pulse.
- R9: Changing one filter's enable changes no other filter's `flt_run`, `flt_init` or `flt_stclr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for the whole subsystem |
| ch_en | input | NUM_CH | Per-channel enable bits |
| ch_src_sel | input | NUM_CH | Per-channel source: 0 serial, 1 parallel |
| flt_en | input | NUM_FLT | Per-filter enable bits |
| ch_act | output | NUM_CH | Channel may take in data |
| ch_ser_act | output | NUM_CH | Channel active on the serial receiver |
| ch_par_act | output | NUM_CH | Channel active on the parallel word path |
| flt_run | output | NUM_FLT | Filter running level |
| flt_init | output | NUM_FLT | One-cycle reinitialize strobe for sinc and integrator |
| flt_stclr | output | NUM_FLT | One-cycle abort and status-clear strobe |
| clk_stop_req | output | 1 | Request to gate the processing clock; all filters idle |

## Verification
The channel qualifiers are driven with complementary enable and source-select masks. These tell an enable/select swap apart from a correct AND, and they show serial-versus-parallel routing bit by bit. The filter enables are walked one bit at a time, then counted through every pattern. This separates a rise strobe from a level and exposes any coupling between neighbouring filters.

The global enable is dropped and raised while individual enables stay set. This tells the two-level hierarchy apart from a per-bit-only gate, and shows whether every running filter strobes together. Reset is applied mid-run to confirm that strobes start again from idle.

// File: rtl/sdf_ctrl_pkg.sv
package sdf_ctrl_pkg;
  typedef enum logic {
    SRC_SERIAL   = 1'b0,
    SRC_PARALLEL = 1'b1
  } src_sel_e;
endpackage

// File: rtl/sdf_chan_gate.sv
module sdf_chan_gate
  import sdf_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic glb_en,
  input  logic ch_en,
  input  logic src_sel,
  output logic ch_act,
  output logic ser_act,
  output logic par_act
);
  logic     live;
  src_sel_e src;

  assign live = glb_en & ch_en;
  assign src  = src_sel_e'(src_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_act  <= 1'b0;
      ser_act <= 1'b0;
      par_act <= 1'b0;
    end else begin
      ch_act  <= live;
      ser_act <= live && (src == SRC_SERIAL);
      par_act <= live && (src == SRC_PARALLEL);
    end
  end

  // R2: the two source qualifiers never overlap
  a_r2_route_excl: assert property (@(posedge clk) disable iff (rst)
    !(ser_act && par_act));
  // R2: an active channel always lands on exactly one path
  a_r2_route_cover: assert property (@(posedge clk) disable iff (rst)
    ch_act |-> (ser_act || par_act));
  // R1: no channel is active after a cycle with the global enable low
  a_r1_global_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en) |-> !ch_act);
endmodule

// File: rtl/sdf_flt_seq.sv
module sdf_flt_seq (
  input  logic clk,
  input  logic rst,
  input  logic glb_en,
  input  logic flt_en,
  output logic eff_en,
  output logic run,
  output logic init_stb,
  output logic stclr_stb
);
  assign eff_en = glb_en & flt_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      init_stb  <= 1'b0;
      stclr_stb <= 1'b0;
    end else begin
      run       <= eff_en;
      init_stb  <= eff_en & ~run;
      stclr_stb <= ~eff_en & run;
    end
  end

  // R4: the initialize strobe lasts one cycle
  a_r4_init_single: assert property (@(posedge clk) disable iff (rst)
    init_stb |=> !init_stb);
  // R4: the strobe coincides with the run level rising
  a_r4_init_on_rise: assert property (@(posedge clk) disable iff (rst)
    init_stb |-> (run && !$past(run)));
  // R5: the status clear coincides with the run level falling
  a_r5_stclr_on_fall: assert property (@(posedge clk) disable iff (rst)
    stclr_stb |-> (!run && $past(run)));
  // R5: the two strobes are mutually exclusive
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(init_stb && stclr_stb));
  // R3: a rise of run is always announced by an initialize strobe
  a_r3_rise_has_init: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> init_stb);
endmodule

// File: rtl/sdf_clk_idle.sv
module sdf_clk_idle #(
  parameter int NUM_FLT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FLT-1:0] eff_en,
  input  logic [NUM_FLT-1:0] flt_run,
  output logic               stop_req
);
  always_ff @(posedge clk) begin
    if (rst) stop_req <= 1'b1;
    else     stop_req <= ~|eff_en;
  end

  // R7: stop request only while no filter runs
  a_r7_idle_match: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> (flt_run == '0));
  // R7: request withdrawn whenever any filter runs
  a_r7_busy_match: assert property (@(posedge clk) disable iff (rst)
    !stop_req |-> (flt_run != '0));
endmodule

// File: rtl/sdf_run_ctrl.sv
module sdf_run_ctrl #(
  parameter int NUM_CH  = 8,
  parameter int NUM_FLT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_en,
  input  logic [NUM_CH-1:0]  ch_en,
  input  logic [NUM_CH-1:0]  ch_src_sel,
  input  logic [NUM_FLT-1:0] flt_en,
  output logic [NUM_CH-1:0]  ch_act,
  output logic [NUM_CH-1:0]  ch_ser_act,
  output logic [NUM_CH-1:0]  ch_par_act,
  output logic [NUM_FLT-1:0] flt_run,
  output logic [NUM_FLT-1:0] flt_init,
  output logic [NUM_FLT-1:0] flt_stclr,
  output logic               clk_stop_req
);
  logic [NUM_FLT-1:0] eff_en;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sdf_chan_gate u_gate (
      .clk     (clk),
      .rst     (rst),
      .glb_en  (glb_en),
      .ch_en   (ch_en[c]),
      .src_sel (ch_src_sel[c]),
      .ch_act  (ch_act[c]),
      .ser_act (ch_ser_act[c]),
      .par_act (ch_par_act[c])
    );
  end

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    sdf_flt_seq u_seq (
      .clk       (clk),
      .rst       (rst),
      .glb_en    (glb_en),
      .flt_en    (flt_en[f]),
      .eff_en    (eff_en[f]),
      .run       (flt_run[f]),
      .init_stb  (flt_init[f]),
      .stclr_stb (flt_stclr[f])
    );
  end

  sdf_clk_idle #(.NUM_FLT(NUM_FLT)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .eff_en   (eff_en),
    .flt_run  (flt_run),
    .stop_req (clk_stop_req)
  );

  // R6: global disable empties every channel and filter together
  a_r6_global_off: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_en) |-> (flt_run == '0 && ch_act == '0));
  // R6: a global drop under running filters raises their status clears
  a_r6_drop_clears: assert property (@(posedge clk) disable iff (rst)
    (!$past(glb_en) && $past(flt_run) != '0) |-> (flt_stclr == $past(flt_run)));
endmodule

// File: tb/sdf_run_ctrl_tb_top.sv
module sdf_run_ctrl_tb_top;
  localparam int NC = 8;
  localparam int NF = 4;

  typedef struct packed {
    logic [NC-1:0] act;
    logic [NC-1:0] ser;
    logic [NC-1:0] par;
    logic [NF-1:0] run;
    logic [NF-1:0] init;
    logic [NF-1:0] stclr;
    logic          stop;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b0;
  logic [NC-1:0] ch_en = '0;
  logic [NC-1:0] ch_src_sel = '0;
  logic [NF-1:0] flt_en = '0;
  logic [NC-1:0] ch_act, ch_ser_act, ch_par_act;
  logic [NF-1:0] flt_run, flt_init, flt_stclr;
  logic clk_stop_req;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [NF-1:0] m_eff = '0;
  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  sdf_run_ctrl #(.NUM_CH(NC), .NUM_FLT(NF)) dut_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en),
    .ch_src_sel(ch_src_sel), .flt_en(flt_en), .ch_act(ch_act),
    .ch_ser_act(ch_ser_act), .ch_par_act(ch_par_act), .flt_run(flt_run),
    .flt_init(flt_init), .flt_stclr(flt_stclr), .clk_stop_req(clk_stop_req)
  );

  task automatic do_reset(input string note);
    exp_t e;
    @(negedge clk);
    rst = 1'b1;
    e = '0;
    e.stop = 1'b1;
    m_eff = '0;
    exp_q.push_back(e);
    tag_q.push_back(note);
  endtask

  task automatic drive(input logic g, input logic [NC-1:0] ce,
                       input logic [NC-1:0] sel, input logic [NF-1:0] fe,
                       input string note);
    exp_t e;
    logic [NF-1:0] eff;
    @(negedge clk);
    rst = 1'b0;
    glb_en = g;
    ch_en = ce;
    ch_src_sel = sel;
    flt_en = fe;
    eff = {NF{g}} & fe;
    e.act = {NC{g}} & ce;
    e.ser = e.act & ~sel;
    e.par = e.act & sel;
    e.run = eff;
    e.init = eff & ~m_eff;
    e.stclr = ~eff & m_eff;
    e.stop = ~|eff;
    m_eff = eff;
    exp_q.push_back(e);
    tag_q.push_back(note);
  endtask

  exp_t  mon_e;
  string mon_t;
  logic  bad;
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      vectors++;
      bad = 1'b0;
      if (ch_act !== mon_e.act) begin
        $display("FAIL R1 [%s] ch_act got %h exp %h", mon_t, ch_act, mon_e.act); bad = 1'b1;
      end
      if (ch_ser_act !== mon_e.ser || ch_par_act !== mon_e.par) begin
        $display("FAIL R2 [%s] ser/par got %h/%h exp %h/%h", mon_t,
                 ch_ser_act, ch_par_act, mon_e.ser, mon_e.par); bad = 1'b1;
      end
      if (flt_run !== mon_e.run) begin
        $display("FAIL R3 [%s] flt_run got %h exp %h", mon_t, flt_run, mon_e.run); bad = 1'b1;
      end
      if (flt_init !== mon_e.init) begin
        $display("FAIL R4 [%s] flt_init got %h exp %h", mon_t, flt_init, mon_e.init); bad = 1'b1;
      end
      if (flt_stclr !== mon_e.stclr) begin
        $display("FAIL R5 [%s] flt_stclr got %h exp %h", mon_t, flt_stclr, mon_e.stclr); bad = 1'b1;
      end
      if (clk_stop_req !== mon_e.stop) begin
        $display("FAIL R7 [%s] clk_stop_req got %b exp %b", mon_t, clk_stop_req, mon_e.stop); bad = 1'b1;
      end
      if (bad) miscompares++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    do_reset("R8 reset state");
    do_reset("R8 reset held");
    drive(1'b0, 8'hFF, 8'h00, 4'hF, "R6 global low masks all");
    drive(1'b1, 8'hA5, 8'h0F, 4'h0, "R1 R2 channel mask A");
    drive(1'b1, 8'h5A, 8'hF0, 4'h0, "R1 R2 channel mask B");
    drive(1'b1, 8'hFF, 8'hFF, 4'h1, "R4 filter0 rise");
    drive(1'b1, 8'hFF, 8'hFF, 4'h1, "R4 steady no strobe");
    drive(1'b1, 8'hFF, 8'h00, 4'h3, "R9 filter1 rise only");
    drive(1'b1, 8'hFF, 8'h00, 4'h2, "R5 R9 filter0 fall");
    drive(1'b1, 8'hFF, 8'h00, 4'h2, "R5 steady no clear");
    drive(1'b0, 8'hFF, 8'h00, 4'hF, "R6 global drop");
    drive(1'b0, 8'hFF, 8'h00, 4'hF, "R6 global held low");
    drive(1'b1, 8'hFF, 8'h00, 4'hF, "R7 global rise all init");
    drive(1'b1, 8'h00, 8'h00, 4'h0, "R7 all idle again");
    drive(1'b1, 8'h00, 8'h00, 4'h0, "R7 idle steady");
    for (int i = 0; i < 32; i++)
      drive(1'b1, 8'(i * 37), 8'(i * 11), 4'(i), "R9 pattern sweep");
    for (int i = 0; i < NF; i++)
      drive(1'b1, 8'(1 << i), 8'(1 << (i + 1)), 4'(1 << i), "R9 walking filter");
    drive(1'b1, 8'hFF, 8'hAA, 4'hF, "R3 all running");
    do_reset("R8 reset mid-run");
    drive(1'b1, 8'hFF, 8'h55, 4'hF, "R8 init after reset");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule